// File: doc/BRIEF.md
# Output Impedance Calibration Stepper

This block keeps the 5-bit strength code of an output driver locked to an external impedance comparator. The comparator reports one bit per cycle: whether the driver strength should go up or down. The block takes that bit into account only once per fixed evaluation interval. At each evaluation it moves a pending code by exactly one step toward the requested direction. The pending code stops at the two ends of the range and never wraps.

The live code that reaches the driver transistors must never move while the pad is actively driving. So the pending code is copied to the live code only at the clock edge on which the pad enters high impedance. A pad that simply stays in high impedance does not cause further copies. The caller supplies a synchronous high-impedance flag, which is asserted for write cycles, deselected cycles, and output-enable deassertions that meet setup and hold.

After reset both codes start at mid-scale. A warm-up counter measures a long settling interval. A status flag then rises at the first entry into high impedance that comes after the interval is over, and stays high until the next reset.

Top module: `zcal_stepper`

## Requirements
- R1: While `rst_n` is low and right after it is released, `drv_code` and `pend_code` are 16, and `eval_tick` and `cal_settled` are 0.
- R2: `eval_tick` is high for one cycle in every 64. It is first high in the 64th cycle after reset is released, which is the cycle before the 64th rising edge.
- R3: On a rising edge where `eval_tick` is high, `pend_code` goes up by one if `cmp_up` is 1 and down by one if `cmp_up` is 0. On every other edge `pend_code` holds its value.
- R4: `pend_code` saturates. An up step at 31 leaves 31, and a down step at 0 leaves 0.
- R5: `drv_code` changes only on a rising edge where `hiz` is 1 and `hiz` was 0 at the previous edge (an entry into high impedance). On that edge it takes the value `pend_code` had just before the edge.
- R6: While `hiz` stays high, later changes of `pend_code` do not reach `drv_code` until the next entry into high impedance.
- R7: `cal_settled` rises on the first entry into high impedance that happens after at least 4096 rising edges since reset. It never rises earlier, and once high it stays high until reset.
- R8: A `hiz` that is already high when reset is released does not count as an entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_up | input | 1 | Comparator direction: 1 asks for a higher code, 0 asks for a lower code |
| hiz | input | 1 | Output is in high impedance during this cycle |
| drv_code | output | 5 | Live driver strength code |
| pend_code | output | 5 | Pending code that tracks the comparator |
| eval_tick | output | 1 | Evaluation cycle strobe |
| cal_settled | output | 1 | Warm-up done and the code has been applied at least once after it |

## Verification
The hardest case to reach is a `cal_settled` rise that depends on the ordering of the warm-up boundary and the entries into high impedance. Several entries must come before cycle 4096 and must not set the flag, and the first entry after that cycle must set it. Getting there takes thousands of cycles. A directed prologue first drives the pending code into both saturation ends while `hiz` is held high or low for long stretches, which covers R4, R6 and R8 and places early entries before the boundary. Seeded random toggling of `hiz` and `cmp_up` then runs well past cycle 4096. A bench model tracks every output in every cycle.

// File: rtl/zcal_pkg.sv
package zcal_pkg;

  // One saturating step of a code in the range 0..top toward the requested direction.
  function automatic int unsigned zcal_next_code(input int unsigned cur,
                                                 input logic        up,
                                                 input int unsigned top);
    int unsigned res;
    res = cur;
    if (up) begin
      if (cur < top) res = cur + 1;
    end else begin
      if (cur > 0) res = cur - 1;
    end
    return res;
  endfunction

endpackage

// File: rtl/zcal_period_timer.sv
module zcal_period_timer #(
  parameter int EVAL_PERIOD = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (EVAL_PERIOD > 1) ? $clog2(EVAL_PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(EVAL_PERIOD - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign tick = (cnt_q == LAST);

  generate
    if ((1 << CW) == EVAL_PERIOD) begin : g_pow2
      // A power-of-two period wraps by itself.
      assign cnt_d = cnt_q + CW'(1);
    end else begin : g_any
      assign cnt_d = tick ? '0 : cnt_q + CW'(1);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: strobe is a single-cycle pulse
  a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/zcal_code_step.sv
module zcal_code_step #(
  parameter int CODE_W     = 5,
  parameter int RESET_CODE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              up,
  output logic [CODE_W-1:0] pend
);
  import zcal_pkg::*;

  localparam int unsigned TOP = (1 << CODE_W) - 1;
  localparam logic [CODE_W-1:0] TOP_V = CODE_W'(TOP);

  logic [CODE_W-1:0] step_val;

  assign step_val = CODE_W'(zcal_next_code(int'(pend), up, TOP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pend <= CODE_W'(RESET_CODE);
    else if (tick) pend <= step_val;
  end

  // R3: no movement outside an evaluation
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pend));
  // R3: an up step below the top adds one
  a_r3_up: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && up && pend != TOP_V) |=> pend == $past(pend) + CODE_W'(1));
  // R3: a down step above zero subtracts one
  a_r3_dn: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !up && pend != '0) |=> pend == $past(pend) - CODE_W'(1));
  // R4: saturation at both ends
  a_r4_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && up && pend == TOP_V) |=> pend == TOP_V);
  a_r4_sat_bot: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !up && pend == '0) |=> pend == '0);

endmodule

// File: rtl/zcal_hiz_apply.sv
module zcal_hiz_apply #(
  parameter int CODE_W     = 5,
  parameter int RESET_CODE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hiz,
  input  logic [CODE_W-1:0] pend,
  output logic              hiz_entry,
  output logic [CODE_W-1:0] drv
);
  logic hiz_q;

  assign hiz_entry = hiz && !hiz_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hiz_q <= 1'b1;   // released reset counts as already in high impedance
      drv   <= CODE_W'(RESET_CODE);
    end else begin
      hiz_q <= hiz;
      if (hiz_entry) drv <= pend;
    end
  end

  // R5: live code is frozen outside an entry edge
  a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !hiz_entry |=> $stable(drv));
  // R5: entry loads the pending value
  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    hiz_entry |=> drv == $past(pend));

endmodule

// File: rtl/zcal_warmup.sv
module zcal_warmup #(
  parameter int WARMUP_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hiz_entry,
  output logic settled
);
  localparam int WW = $clog2(WARMUP_CYCLES + 1);
  localparam logic [WW-1:0] WLIM = WW'(WARMUP_CYCLES);

  logic [WW-1:0] wcnt;
  logic          warm_done;

  assign warm_done = (wcnt == WLIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt    <= '0;
      settled <= 1'b0;
    end else begin
      if (!warm_done) wcnt <= wcnt + WW'(1);
      if (hiz_entry && warm_done) settled <= 1'b1;
    end
  end

  // R7: flag is sticky
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    settled |=> settled);
  // R7: flag rises only from an entry after warm-up
  a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !settled && !(hiz_entry && warm_done) |=> !settled);

endmodule

// File: rtl/zcal_stepper.sv
module zcal_stepper #(
  parameter int CODE_W        = 5,
  parameter int EVAL_PERIOD   = 64,
  parameter int WARMUP_CYCLES = 4096,
  parameter int RESET_CODE    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_up,
  input  logic              hiz,
  output logic [CODE_W-1:0] drv_code,
  output logic [CODE_W-1:0] pend_code,
  output logic              eval_tick,
  output logic              cal_settled
);
  logic hiz_entry;

  zcal_period_timer #(.EVAL_PERIOD(EVAL_PERIOD)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (eval_tick)
  );

  zcal_code_step #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_step (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (eval_tick),
    .up   (cmp_up),
    .pend (pend_code)
  );

  zcal_hiz_apply #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_apply (
    .clk      (clk),
    .rst_n    (rst_n),
    .hiz      (hiz),
    .pend     (pend_code),
    .hiz_entry(hiz_entry),
    .drv      (drv_code)
  );

  zcal_warmup #(.WARMUP_CYCLES(WARMUP_CYCLES)) u_warm (
    .clk      (clk),
    .rst_n    (rst_n),
    .hiz_entry(hiz_entry),
    .settled  (cal_settled)
  );

  // R8: a high level carried through reset release is not an entry
  a_r8_no_entry_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !hiz_entry || !$past(hiz));

endmodule

// File: tb/test_zcal_stepper.sv
module test_zcal_stepper;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_up = 1'b0;
  logic       hiz = 1'b1;
  logic [4:0] drv_code, pend_code;
  logic       eval_tick, cal_settled;

  int checks = 0;
  int fails  = 0;

  // bench model state
  int m_phase, m_pend, m_drv, m_edges;
  bit m_prev_hiz, m_settled;

  always #4 clk = ~clk;   // 125 MHz

  zcal_stepper i_zcal_stepper (
    .clk(clk), .rst_n(rst_n), .cmp_up(cmp_up), .hiz(hiz),
    .drv_code(drv_code), .pend_code(pend_code),
    .eval_tick(eval_tick), .cal_settled(cal_settled)
  );

  function automatic int clamp_step(int v, bit up);
    int t;
    t = up ? v + 1 : v - 1;
    if (t > 31) t = 31;
    if (t < 0) t = 0;
    return t;
  endfunction

  function automatic bit tick_expected(int phase);
    return (phase % 64) == 63;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_phase = 0; m_pend = 16; m_drv = 16; m_edges = 0;
    m_prev_hiz = 1'b1; m_settled = 1'b0;
  endtask

  // one clock: advance model at the edge, compare at the falling edge
  task automatic cyc();
    bit entry;
    @(posedge clk);
    entry = hiz && !m_prev_hiz;
    if (entry) begin
      if (m_edges >= 4096) m_settled = 1'b1;
      m_drv = m_pend;
    end
    if (tick_expected(m_phase)) m_pend = clamp_step(m_pend, cmp_up);
    m_phase++;
    m_prev_hiz = hiz;
    m_edges++;
    @(negedge clk);
    chk(eval_tick == tick_expected(m_phase), "R2 eval_tick", eval_tick, tick_expected(m_phase));
    chk(pend_code == m_pend, "R3/R4 pend_code", pend_code, m_pend);
    chk(drv_code == m_drv, "R5/R6 drv_code", drv_code, m_drv);
    chk(cal_settled == m_settled, "R7 cal_settled", cal_settled, m_settled);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    int unsigned seed;
    seed = 32'h5eed_0a11;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: state under reset
    chk(drv_code == 5'd16, "R1 drv_code in reset", drv_code, 16);
    chk(pend_code == 5'd16, "R1 pend_code in reset", pend_code, 16);
    chk(cal_settled == 1'b0, "R1 cal_settled in reset", cal_settled, 0);
    chk(eval_tick == 1'b0, "R1 eval_tick in reset", eval_tick, 0);
    rst_n = 1'b1;

    // R8/R6: hiz held high across release, pend climbs, drv must not follow
    hiz = 1'b1; cmp_up = 1'b1;
    repeat (200) cyc();
    chk(pend_code == 5'd19, "R8 pend after 3 ticks", pend_code, 19);
    chk(drv_code == 5'd16, "R8 no entry at release", drv_code, 16);

    // R4: saturate at top while driving
    hiz = 1'b0;
    repeat (64 * 16) cyc();
    chk(pend_code == 5'd31, "R4 top saturation", pend_code, 31);
    chk(drv_code == 5'd16, "R5 frozen while driving", drv_code, 16);

    // R5: entry loads 31; R7: too early to settle
    hiz = 1'b1;
    cyc();
    chk(drv_code == 5'd31, "R5 entry loads pending", drv_code, 31);
    chk(cal_settled == 1'b0, "R7 early entry no settle", cal_settled, 0);

    // R4/R6: walk down to zero while staying in high impedance
    cmp_up = 1'b0;
    repeat (64 * 34) cyc();
    chk(pend_code == 5'd0, "R4 bottom saturation", pend_code, 0);
    chk(drv_code == 5'd31, "R6 hold while hiz stays high", drv_code, 31);

    // R5: new entry copies zero
    hiz = 1'b0; cyc();
    hiz = 1'b1; cyc();
    chk(drv_code == 5'd0, "R5 re-entry loads zero", drv_code, 0);
    chk(cal_settled == 1'b0, "R7 still before warm-up", cal_settled, 0);

    // random phase, crossing the warm-up boundary
    hiz = 1'b0;
    for (int i = 0; i < 12000; i++) begin
      if (($urandom(seed) % 8) == 0) hiz = ~hiz;
      seed = seed * 32'd1103515245 + 32'd12345;
      cmp_up = (($urandom(seed) % 3) != 0) ^ (i >= 6000);
      seed = seed * 32'd1103515245 + 32'd12345;
      cyc();
    end

    // R7: force one more entry and confirm the flag
    hiz = 1'b0; cyc();
    hiz = 1'b1; cyc();
    chk(cal_settled == 1'b1, "R7 settled after warm-up", cal_settled, 1);
    repeat (100) cyc();
    chk(cal_settled == 1'b1, "R7 settled is sticky", cal_settled, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule